// File: doc/BRIEF.md
# Load-Balancing Issue-Port Binder

This block sits between an in-order front end and a reservation station. It looks at each group of micro-operations being written into the station and picks, for every slot, which of two redundant execution ports the operation will use. Once picked, the port does not change. Operations that only one port can execute go to that port. Operations that either port can execute are spread between the two, using a running count of how many operations each port already holds.

Two occupancy counters do the bookkeeping. A counter rises for each operation bound to its port. It falls by one for each dispatch pulse from that port. When the two counts are close, flexible operations in the group are interleaved between the ports by slot parity, and the direction of the interleave follows the sign of the small imbalance. Once one port leads by two or more, every flexible operation in the group goes to the other port. All decisions in a cycle use the counts held at the start of that cycle. Every update from the group and from dispatch lands together at the clock edge. There is no look-ahead past the current group.

Top module: `pab_port_binder`

## Requirements
- R1: After reset both occupancy counts are zero, so a full group of flexible slots binds slot 0 to port 0, slot 1 to port 1 and slot 2 to port 0.
- R2: A valid slot whose eligibility mask has exactly one bit set is bound to that port, whatever the balance. Mask bit 2i+0 means slot i may use port 0, and bit 2i+1 means it may use port 1.
- R3: Each bound slot adds one to the count of the port it is bound to, including single-port slots. The new count is visible from the next cycle.
- R4: A dispatch pulse on `done[p]` takes one from the count of port p. The design flags a pulse while that count is zero as a protocol error.
- R5: With d = count0 − count1 in {−1, 0}, flexible slots with even index go to port 0 and those with odd index go to port 1.
- R6: With d = +1, flexible slots with even index go to port 1 and those with odd index go to port 0.
- R7: With d ≥ +2, every flexible slot in the group goes to port 1.
- R8: With d ≤ −2, every flexible slot in the group goes to port 0.
- R9: All slots in a group are decided from the counts at the start of the cycle. Increments from the group and decrements from same-cycle dispatches are applied together at the next edge.
- R10: A count never exceeds the station depth (32). Increments beyond it are dropped, and the next dispatch lowers the count from 32.
- R11: A slot that is not valid, or whose mask is 00, is not bound (`bind_ok` low) and changes no count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_vld | input | SLOTS | Per-slot valid for the issue group |
| grp_elig | input | 2*SLOTS | Per-slot port eligibility, two bits per slot (bit 2i: port 0, bit 2i+1: port 1) |
| done | input | 2 | Per-port dispatch pulse, one operation leaves the station |
| bind_ok | output | SLOTS | Slot was bound to a port this cycle |
| bind_port | output | SLOTS | Chosen port per slot (0 or 1), meaningful when bind_ok is set |

## Verification
The bound checker watches several properties on every cycle:
- single-port slots always go to their own port;
- flexible slots follow the heavy-imbalance rule whenever one counter leads by two;
- invalid slots stay unbound;
- counts stay within the depth and do not move in an idle cycle;
- no dispatch pulse arrives on an empty port.

Other behaviour only the bench's scenarios can show: the parity interleave for small imbalances and its flip at d = +1, the arithmetic of combined increments and decrements in one cycle, and saturation followed by recovery at the depth limit. The bench shows these by replaying a software model of the counters through an exhaustive sweep of valid and eligibility patterns and a long pseudo-random run.

// File: rtl/pab_pkg.sv
package pab_pkg;

   // Balance class of the two occupancy counts, d = occ0 - occ1
   typedef enum logic [1:0] {
      BAL_EVEN   = 2'd0,   // d in {-1, 0}
      BAL_PLUS1  = 2'd1,   // d == +1
      BAL_HEAVY0 = 2'd2,   // d >= +2 : port 0 loaded
      BAL_HEAVY1 = 2'd3    // d <= -2 : port 1 loaded
   } bal_e;

   localparam int unsigned NUM_PORTS = 2;
   localparam int HEAVY_GAP = 2;

endpackage

// File: rtl/pab_balance_class.sv
module pab_balance_class
   import pab_pkg::*;
#(
   parameter int unsigned CW = 6
) (
   input  logic [CW-1:0] occ0,
   input  logic [CW-1:0] occ1,
   output bal_e          cls
);

   localparam int unsigned DW = CW + 1;

   logic signed [DW-1:0] diff;

   always_comb begin
      diff = $signed({1'b0, occ0}) - $signed({1'b0, occ1});
      if (diff >= $signed(DW'(HEAVY_GAP)))
         cls = BAL_HEAVY0;
      else if (diff <= -$signed(DW'(HEAVY_GAP)))
         cls = BAL_HEAVY1;
      else if (diff == $signed(DW'(1)))
         cls = BAL_PLUS1;
      else
         cls = BAL_EVEN;
   end

endmodule

// File: rtl/pab_slot_pick.sv
module pab_slot_pick
   import pab_pkg::*;
#(
   parameter int unsigned SLOT_IDX     = 0,
   parameter bit          SPREAD_SMALL = 1'b1
) (
   input  logic       vld,
   input  logic [1:0] elig,
   input  bal_e       cls,
   output logic       bound,
   output logic       port
);

   // Port chosen for a flexible slot when the imbalance is small
   logic pick_even;
   logic pick_plus1;

   generate
      if (SPREAD_SMALL) begin : g_spread
         localparam bit ODD = ((SLOT_IDX % 2) == 1);
         assign pick_even  = ODD;
         assign pick_plus1 = ~ODD;
      end else begin : g_lump
         assign pick_even  = 1'b0;
         assign pick_plus1 = 1'b1;
      end
   endgenerate

   always_comb begin
      bound = 1'b0;
      port  = 1'b0;
      if (vld) begin
         unique case (elig)
            2'b00: begin
               bound = 1'b0;
               port  = 1'b0;
            end
            2'b01: begin
               bound = 1'b1;
               port  = 1'b0;
            end
            2'b10: begin
               bound = 1'b1;
               port  = 1'b1;
            end
            default: begin
               bound = 1'b1;
               unique case (cls)
                  BAL_HEAVY0: port = 1'b1;
                  BAL_HEAVY1: port = 1'b0;
                  BAL_PLUS1:  port = pick_plus1;
                  default:    port = pick_even;
               endcase
            end
         endcase
      end
   end

endmodule

// File: rtl/pab_occ_counter.sv
module pab_occ_counter #(
   parameter int unsigned SLOTS = 3,
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SLOTS-1:0] grant,
   input  logic             done,
   output logic [CW-1:0]    occ
);

   localparam int unsigned SW = CW + 2;

   logic [SW-1:0] inc;
   logic [SW-1:0] sum;
   logic [SW-1:0] nxt;

   always_comb begin
      inc = '0;
      for (int i = 0; i < SLOTS; i++)
         inc = inc + SW'(grant[i]);
      sum = SW'(occ) + inc;
      if (sum < SW'(done))
         nxt = '0;
      else
         nxt = sum - SW'(done);
      if (nxt > SW'(DEPTH))
         nxt = SW'(DEPTH);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         occ <= '0;
      else
         occ <= nxt[CW-1:0];
   end

endmodule

// File: rtl/pab_port_binder.sv
module pab_port_binder
   import pab_pkg::*;
#(
   parameter int unsigned SLOTS        = 3,
   parameter int unsigned DEPTH        = 32,
   parameter bit          SPREAD_SMALL = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SLOTS-1:0]   grp_vld,
   input  logic [2*SLOTS-1:0] grp_elig,
   input  logic [1:0]         done,
   output logic [SLOTS-1:0]   bind_ok,
   output logic [SLOTS-1:0]   bind_port
);

   localparam int unsigned CW = $clog2(DEPTH + 1);

   generate
      if (SLOTS < 1) begin : g_bad_slots
         $error("pab_port_binder: SLOTS must be at least 1");
      end
      if (DEPTH < SLOTS) begin : g_bad_depth
         $error("pab_port_binder: DEPTH must be at least SLOTS");
      end
   endgenerate

   logic [CW-1:0]    occ   [NUM_PORTS];
   logic [SLOTS-1:0] grant [NUM_PORTS];
   bal_e             cls;

   pab_balance_class #(.CW(CW)) u_cls (
      .occ0 (occ[0]),
      .occ1 (occ[1]),
      .cls  (cls)
   );

   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      pab_slot_pick #(
         .SLOT_IDX     (s),
         .SPREAD_SMALL (SPREAD_SMALL)
      ) u_pick (
         .vld   (grp_vld[s]),
         .elig  (grp_elig[2*s +: 2]),
         .cls   (cls),
         .bound (bind_ok[s]),
         .port  (bind_port[s])
      );
      assign grant[0][s] = bind_ok[s] & ~bind_port[s];
      assign grant[1][s] = bind_ok[s] &  bind_port[s];
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      pab_occ_counter #(
         .SLOTS (SLOTS),
         .DEPTH (DEPTH),
         .CW    (CW)
      ) u_occ (
         .clk   (clk),
         .rst_n (rst_n),
         .grant (grant[p]),
         .done  (done[p]),
         .occ   (occ[p])
      );
   end

endmodule

// File: rtl/pab_port_binder_chk.sv
module pab_port_binder_chk #(
   parameter int unsigned SLOTS = 3,
   parameter int unsigned DEPTH = 32,
   parameter int unsigned CW    = $clog2(DEPTH + 1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic [SLOTS-1:0]   grp_vld,
   input logic [2*SLOTS-1:0] grp_elig,
   input logic [1:0]         done,
   input logic [SLOTS-1:0]   bind_ok,
   input logic [SLOTS-1:0]   bind_port,
   input logic [CW-1:0]      occ0,
   input logic [CW-1:0]      occ1
);

   int gap;
   always_comb gap = int'(occ0) - int'(occ1);

   for (genvar s = 0; s < SLOTS; s++) begin : g_s
      // R2: single-port slots go to their own port
      a_r2_only_port0: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_vld[s] && grp_elig[2*s +: 2] == 2'b01) |-> (bind_ok[s] && !bind_port[s]));
      a_r2_only_port1: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_vld[s] && grp_elig[2*s +: 2] == 2'b10) |-> (bind_ok[s] && bind_port[s]));
      // R7: port 0 leads by two or more
      a_r7_heavy0: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_vld[s] && grp_elig[2*s +: 2] == 2'b11 && gap >= 2) |-> bind_port[s]);
      // R8: port 1 leads by two or more
      a_r8_heavy1: assert property (@(posedge clk) disable iff (!rst_n)
         (grp_vld[s] && grp_elig[2*s +: 2] == 2'b11 && gap <= -2) |-> !bind_port[s]);
      // R11: invalid slots are never bound
      a_r11_idle_slot: assert property (@(posedge clk) disable iff (!rst_n)
         (!grp_vld[s] || grp_elig[2*s +: 2] == 2'b00) |-> !bind_ok[s]);
   end

   // R10: counts stay within the station depth
   a_r10_cap: assert property (@(posedge clk) disable iff (!rst_n)
      (occ0 <= CW'(DEPTH)) && (occ1 <= CW'(DEPTH)));

   // R4: no dispatch from an empty port
   a_r4_no_empty_dec0: assert property (@(posedge clk) disable iff (!rst_n)
      done[0] |-> (occ0 != '0));
   a_r4_no_empty_dec1: assert property (@(posedge clk) disable iff (!rst_n)
      done[1] |-> (occ1 != '0));

   // R9: no binding and no dispatch leaves both counts unchanged
   a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bind_ok == '0 && done == 2'b00) |=> ($stable(occ0) && $stable(occ1)));

endmodule

bind pab_port_binder pab_port_binder_chk #(
   .SLOTS (SLOTS),
   .DEPTH (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .grp_vld   (grp_vld),
   .grp_elig  (grp_elig),
   .done      (done),
   .bind_ok   (bind_ok),
   .bind_port (bind_port),
   .occ0      (occ[0]),
   .occ1      (occ[1])
);

// File: tb/pab_port_binder_test.sv
`timescale 1ns/1ps
module pab_port_binder_test;

   localparam int SLOTS = 3;
   localparam int DEPTH = 32;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [SLOTS-1:0] grp_vld = '0;
   logic [5:0]       grp_elig = '0;
   logic [1:0]       done = '0;
   logic [SLOTS-1:0] bind_ok;
   logic [SLOTS-1:0] bind_port;

   int n_cmp = 0;
   int n_bad = 0;
   int m0 = 0;
   int m1 = 0;

   always #2.5 clk = ~clk;

   pab_port_binder #(.SLOTS(SLOTS), .DEPTH(DEPTH)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .grp_vld   (grp_vld),
      .grp_elig  (grp_elig),
      .done      (done),
      .bind_ok   (bind_ok),
      .bind_port (bind_port)
   );

   function automatic int exp_port(int slot, logic [1:0] e, int d);
      if (e == 2'b01) return 0;
      if (e == 2'b10) return 1;
      if (d >= 2)  return 1;
      if (d <= -2) return 0;
      if (d == 1)  return (slot % 2 == 0) ? 1 : 0;
      return (slot % 2 == 0) ? 0 : 1;
   endfunction

   function automatic string auto_tag(logic v, logic [1:0] e, int d);
      if (!v || e == 2'b00) return "R11";
      if (e != 2'b11)       return "R2";
      if (d >= 2)           return "R7";
      if (d <= -2)          return "R8";
      if (d == 1)           return "R6";
      return "R5";
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      grp_vld = '0;
      grp_elig = '0;
      done = '0;
      repeat (2) @(posedge clk);
      #1;
      rst_n = 1'b1;
      m0 = 0;
      m1 = 0;
   endtask

   // Drive one group, compare at the falling edge, update the model at the rising edge
   task automatic step(input logic [2:0] v, input logic [5:0] e, input logic [1:0] dd,
                       input string tag);
      int d;
      int inc0;
      int inc1;
      grp_vld  = v;
      grp_elig = e;
      done     = dd;
      @(negedge clk);
      d = m0 - m1;
      inc0 = 0;
      inc1 = 0;
      for (int i = 0; i < SLOTS; i++) begin
         logic [1:0] ei;
         logic       eb;
         string      t;
         ei = e[2*i +: 2];
         eb = v[i] && (ei != 2'b00);
         t  = (tag != "") ? tag : auto_tag(v[i], ei, d);
         n_cmp++;
         if (bind_ok[i] !== eb) begin
            n_bad++;
            $display("FAIL %s slot %0d bind_ok actual %b expected %b (d=%0d)",
                     t, i, bind_ok[i], eb, d);
         end
         if (eb) begin
            int ep;
            ep = exp_port(i, ei, d);
            n_cmp++;
            if (int'(bind_port[i]) != ep) begin
               n_bad++;
               $display("FAIL %s slot %0d bind_port actual %0d expected %0d (d=%0d)",
                        t, i, bind_port[i], ep, d);
            end
            if (ep == 0) inc0++; else inc1++;
         end
      end
      m0 = m0 + inc0 - int'(dd[0]);
      m1 = m1 + inc1 - int'(dd[1]);
      if (m0 > DEPTH) m0 = DEPTH;
      if (m1 > DEPTH) m1 = DEPTH;
      if (m0 < 0) m0 = 0;
      if (m1 < 0) m1 = 0;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      do_reset();

      // R1: zero counts after reset -> interleave 0,1,0
      step(3'b111, 6'b111111, 2'b00, "R1");
      // counts 2/1 : d=+1, R6 flip
      step(3'b111, 6'b111111, 2'b00, "R6");
      // counts 3/3 : R3 single-port slots still count
      step(3'b011, 6'b000101, 2'b00, "R2");
      // counts 5/3 : d=+2 -> all to port 1
      step(3'b111, 6'b111111, 2'b00, "R3");
      // counts 5/6 ; R4 two dispatches on port 1
      step(3'b000, 6'b000000, 2'b10, "R4");
      step(3'b000, 6'b000000, 2'b10, "R4");
      // counts 5/4 : d=+1 visible only after both decrements
      step(3'b001, 6'b000011, 2'b00, "R4");
      // R9: group and dispatch in the same cycle decided from start counts
      step(3'b111, 6'b111111, 2'b01, "R9");
      step(3'b111, 6'b111111, 2'b00, "R9");
      // R11: invalid or ineligible slots
      step(3'b000, 6'b111111, 2'b00, "R11");
      step(3'b111, 6'b000000, 2'b00, "R11");
      step(3'b101, 6'b110011, 2'b00, "R11");

      // R10: saturate port 0 at the depth, then recover
      do_reset();
      for (int k = 0; k < 13; k++) step(3'b111, 6'b010101, 2'b00, "R10");
      for (int k = 0; k < 10; k++) step(3'b111, 6'b101010, 2'b00, "R10");
      step(3'b000, 6'b000000, 2'b01, "R10");
      step(3'b111, 6'b111111, 2'b00, "R10");

      // Exhaustive sweep of valid and eligibility patterns
      do_reset();
      for (int c = 0; c < 512; c++) begin
         logic [1:0] dd;
         dd[0] = (m0 > 0) && c[0];
         dd[1] = (m1 > 0) && c[1];
         step(c[2:0], c[8:3], dd, "");
         if (m0 > 0 && m1 > 0) step(3'b000, 6'b000000, 2'b11, "");
      end

      // Pseudo-random run with bounded drain
      do_reset();
      for (int k = 0; k < 3000; k++) begin
         logic [31:0] r;
         logic [1:0]  dd;
         r = $urandom;
         dd[0] = (m0 > 0) && (r[9] | r[10]);
         dd[1] = (m1 > 0) && (r[11] | r[12]);
         step(r[2:0], r[8:3], dd, "");
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule